// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the device end of a three-wire write / one-wire read configuration link. A host clocks 32-bit words in on a serial data pin, least significant bit first, and then raises a latch pin. On that latch the collected word is stored in one of seven internal registers. The three lowest bits of the word are its address. Addresses 1 to 6 are control registers, and their contents are presented in parallel to the rest of the chip. Address 0 is a command register. When its top bit is set, the command requests a readback of the register named by bits [30:28].

A readback runs in two phases. The first serial clock after the command's latch is an idle clock and moves no data. The next 32 serial clocks each place one bit of the selected register on the readback pin, least significant bit first. After that the pin falls back to 0. The serial pins are treated as asynchronous. They are synchronised into a faster system clock, and every serial event is acted on as an edge detected in that domain.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is asserted on a system clock edge, all six control registers read 0 on the next cycle, the readback pin is 0 and no readback is pending.
- R2: Serial data is captured on each rising serial clock, bit 0 of the word first and bit 31 last. On a latch rise with address bits [2:0] equal to 1..6, the full 32-bit word is stored in that control register, and the other control registers keep their values.
- R3: A latch whose address bits [2:0] are 111 changes no register and starts no readback.
- R4: A latch to address 0 with bit 31 clear starts no readback: the readback pin stays 0 on every later serial clock, and no control register changes.
- R5: After a latch to address 0 with bit 31 set, the readback pin stays 0 until the first rising serial clock, and it stays 0 through that first (idle) clock.
- R6: Each of the next 32 rising serial clocks drives one bit of the selected register (selected by bits [30:28]) onto the readback pin, in order from bit 0 to bit 31. The bit stays there until the following rising serial clock.
- R7: On the rising serial clock after the 32nd bit, the readback pin returns to 0, and it stays 0 on later clocks.
- R8: Target 000 reads back the command word that requested it. Target 111 reads back 32 zeros.
- R9: When a latch rise and a serial clock rise are detected in the same system cycle, the latch stores the word as it was before that clock's bit was shifted in. That serial clock does not count as the idle clock of a readback that the latch arms.
- R10: A latch rise during a readback ends it at once. The readback pin reads 0 from then on unless a new readback is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdata | input | 1 | Serial data, sampled on rising sclk |
| slatch | input | 1 | Latch enable; its rising edge commits the shifted word |
| rdbk | output | 1 | Serial readback data |
| ctrl_regs | output | 192 | Control registers 1..6; register k sits at bits [32k-1:32(k-1)] |

## Verification
A rising serial clock and a rising latch can be detected in the same system cycle. Two things then compete: the shifter takes in a new bit while the bank commits the word, and the readback sequencer sees an arming command together with a clock that could be mistaken for its idle clock. The bench provokes this by raising sclk and slatch at the same instant, after a complete word has been shifted in. It judges the result in two ways. First, the stored control register must equal the word without the extra bit. Second, after a simultaneous readback command, the next serial clock must still read 0, and the target's bit 0, chosen to be 1, must appear only on the clock after that.

// File: rtl/cfg_port_pkg.sv
// Shared constants and types for the serial configuration port.
// Assumes a 32-bit word whose low bits carry the register address.
package cfg_port_pkg;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int NUM_REGS    = 7;
    localparam int SEL_LSB     = 28;
    localparam int RB_FLAG_BIT = 31;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_ARMED = 2'd1,
        RB_SHIFT = 2'd2
    } rb_state_t;
endpackage

// File: rtl/cfg_pin_sync.sv
// Multi-flop synchroniser for one asynchronous input pin.
// Assumes STAGES >= 2; the output is a clean level in the clk domain.
module cfg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_reg.sv
// Serial-in shift register; the first bit received ends up in bit 0.
// Assumes shift_en is a one-cycle pulse per rising serial clock.
module cfg_shift_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;

    // Insert new bits at the top so earlier bits move toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {din, sr_q[W-1:1]};
    end

    assign word_o = sr_q;

    a_r6_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[W-2:0] == $past(sr_q[W-1:1]));
endmodule

// File: rtl/cfg_reg_bank.sv
// Addressed register bank written by a latch pulse.
// Assumes the address sits in word_i[AW-1:0]; addresses >= NREG are dropped.
module cfg_reg_bank #(
    parameter int W    = 32,
    parameter int AW   = 3,
    parameter int NREG = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] regs_o [NREG]
);
    logic [AW-1:0]     addr;
    logic [NREG-1:0]   we;
    logic [NREG*W-1:0] regs_flat;

    assign addr = word_i[AW-1:0];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic [W-1:0] reg_q;

        assign we[k] = wr_en && (addr == AW'(k));

        // Hold register k; replace it on a matching latch.
        always_ff @(posedge clk) begin
            if (!rst_n)     reg_q <= '0;
            else if (we[k]) reg_q <= word_i;
        end

        assign regs_o[k]            = reg_q;
        assign regs_flat[k*W +: W]  = reg_q;

        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            we[k] |=> reg_q == $past(word_i));
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> regs_flat == '0);

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NREG) |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_readback.sv
// Readback sequencer: armed by a command latch, skips one serial clock,
// then emits the selected register LSB first, one bit per serial clock.
// Assumes latch_rise and sclk_rise are single-cycle pulses; latch has priority.
module cfg_readback #(
    parameter int W        = 32,
    parameter int AW       = 3,
    parameter int NREG     = 7,
    parameter int SEL_LSB  = 28,
    parameter int FLAG_BIT = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_rise,
    input  logic         sclk_rise,
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] regs_i [NREG],
    output logic         rdbk_o
);
    import cfg_port_pkg::*;

    localparam int CNT_W = $clog2(W + 1);

    rb_state_t      state_q;
    logic [W-1:0]   snap_q;
    logic [CNT_W-1:0] cnt_q;
    logic           rdbk_q;
    logic           is_cmd;
    logic [AW-1:0]  sel;
    logic [W-1:0]   pick;

    assign is_cmd = (word_i[AW-1:0] == '0) && word_i[FLAG_BIT];
    assign sel    = word_i[SEL_LSB +: AW];

    // Choose the value to read back; target 0 is the command itself.
    always_comb begin
        pick = '0;
        for (int k = 1; k < NREG; k++) begin
            if (sel == AW'(k)) pick = regs_i[k];
        end
        if (sel == '0) pick = word_i;
    end

    // Sequence the arm, idle clock and 32 data clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RB_IDLE;
            snap_q  <= '0;
            cnt_q   <= '0;
            rdbk_q  <= 1'b0;
        end else if (latch_rise) begin
            rdbk_q <= 1'b0;
            cnt_q  <= '0;
            if (is_cmd) begin
                state_q <= RB_ARMED;
                snap_q  <= pick;
            end else begin
                state_q <= RB_IDLE;
            end
        end else if (sclk_rise) begin
            case (state_q)
                RB_ARMED: begin
                    state_q <= RB_SHIFT;
                    cnt_q   <= '0;
                end
                RB_SHIFT: begin
                    if (cnt_q == CNT_W'(W)) begin
                        state_q <= RB_IDLE;
                        rdbk_q  <= 1'b0;
                    end else begin
                        rdbk_q <= snap_q[0];
                        snap_q <= snap_q >> 1;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rdbk_o = rdbk_q;

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W));

    a_r5_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RB_ARMED && sclk_rise && !latch_rise) |=> !rdbk_o);

    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RB_IDLE) |-> !rdbk_o);

    a_r10_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> !rdbk_o);
endmodule

// File: rtl/cfg_serial_port.sv
// Top of the serial configuration port: synchronises the serial pins,
// detects rising edges, shifts data, commits latched words and runs readback.
// Assumes clk is at least about 8x the serial clock rate.
module cfg_serial_port
    import cfg_port_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int AW       = ADDR_W,
    parameter int NREG     = NUM_REGS,
    parameter int SEL_LO   = SEL_LSB,
    parameter int FLAG_BIT = RB_FLAG_BIT,
    parameter int STAGES   = SYNC_STAGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  sdata,
    input  logic                  slatch,
    output logic                  rdbk,
    output logic [(NREG-1)*W-1:0] ctrl_regs
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_sync;
    logic             sclk_prev_q;
    logic             latch_prev_q;
    logic             sclk_rise;
    logic             latch_rise;
    logic [W-1:0]     word;
    logic [W-1:0]     regs [NREG];

    assign pins_raw = {slatch, sdata, sclk};

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        cfg_pin_sync #(.STAGES(STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(pins_raw[i]),
            .level_o (pins_sync[i])
        );
    end

    // Remember the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q  <= 1'b0;
            latch_prev_q <= 1'b0;
        end else begin
            sclk_prev_q  <= pins_sync[0];
            latch_prev_q <= pins_sync[2];
        end
    end

    assign sclk_rise  = pins_sync[0] && !sclk_prev_q;
    assign latch_rise = pins_sync[2] && !latch_prev_q;

    cfg_shift_reg #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(sclk_rise),
        .din     (pins_sync[1]),
        .word_o  (word)
    );

    cfg_reg_bank #(.W(W), .AW(AW), .NREG(NREG)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (latch_rise),
        .word_i(word),
        .regs_o(regs)
    );

    cfg_readback #(
        .W(W), .AW(AW), .NREG(NREG), .SEL_LSB(SEL_LO), .FLAG_BIT(FLAG_BIT)
    ) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_rise(latch_rise),
        .sclk_rise (sclk_rise),
        .word_i    (word),
        .regs_i    (regs),
        .rdbk_o    (rdbk)
    );

    for (genvar k = 1; k < NREG; k++) begin : g_out
        assign ctrl_regs[(k-1)*W +: W] = regs[k];
    end

    a_r9_edges_single: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);
endmodule

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic         slatch = 1'b0;
    logic         rdbk;
    logic [191:0] ctrl_regs;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] shadow [1:6];

    always #2 clk = ~clk;

    cfg_serial_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .sdata    (sdata),
        .slatch   (slatch),
        .rdbk     (rdbk),
        .ctrl_regs(ctrl_regs)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(int k);
        logic [31:0] v;
        v = 32'h9E37_79B0 ^ (32'(k) << 12);
        return {v[31:3], 3'(k)};
    endfunction

    function automatic logic [31:0] get_reg(int k);
        return ctrl_regs[(k-1)*32 +: 32];
    endfunction

    function automatic logic [31:0] rb_cmd(int sel);
        return {1'b1, 3'(sel), 28'h0};
    endfunction

    task automatic clk_bit(logic b);
        sdata = b;
        #16 sclk = 1'b1;
        #32 sclk = 1'b0;
        #16;
    endtask

    task automatic send_word(logic [31:0] w);
        for (int i = 0; i < 32; i++) clk_bit(w[i]);
    endtask

    task automatic latch_pulse();
        #16 slatch = 1'b1;
        #48 slatch = 1'b0;
        #16;
    endtask

    task automatic rb_clock(output logic b);
        sdata = 1'b0;
        #16 sclk = 1'b1;
        #28 b = rdbk;
        #4 sclk = 1'b0;
        #16;
    endtask

    task automatic check_all_regs(string req);
        for (int k = 1; k <= 6; k++) chk(req, get_reg(k), shadow[k]);
    endtask

    task automatic t_reset();
        check_all_regs("R1 reset");
        chk("R1 rdbk after reset", 32'(rdbk), 32'h0);
    endtask

    task automatic t_write();
        for (int k = 1; k <= 6; k++) begin
            send_word(pattern(k));
            latch_pulse();
            shadow[k] = pattern(k);
            check_all_regs("R2 write");
        end
    endtask

    task automatic t_ignore();
        send_word(32'hFFFF_FFFF);
        latch_pulse();
        check_all_regs("R3 address 111");
        chk("R3 rdbk", 32'(rdbk), 32'h0);
    endtask

    task automatic t_no_rb();
        logic b;
        logic [31:0] seen = '0;
        send_word({1'b0, 3'd3, 28'h0});
        latch_pulse();
        for (int i = 0; i < 34; i++) begin
            rb_clock(b);
            seen[i % 32] = seen[i % 32] | b;
        end
        chk("R4 no readback", seen, 32'h0);
        check_all_regs("R4 regs unchanged");
    endtask

    task automatic t_readback(int sel, logic [31:0] exp);
        logic b;
        logic [31:0] got = '0;
        send_word(rb_cmd(sel));
        latch_pulse();
        chk("R5 before first clock", 32'(rdbk), 32'h0);
        rb_clock(b);
        chk("R5 idle clock", 32'(b), 32'h0);
        for (int i = 0; i < 32; i++) begin
            rb_clock(b);
            got[i] = b;
        end
        chk(sel == 0 || sel == 7 ? "R8 readback word" : "R6 readback word", got, exp);
        rb_clock(b);
        chk("R7 after last bit", 32'(b), 32'h0);
        rb_clock(b);
        chk("R7 stays low", 32'(b), 32'h0);
    endtask

    task automatic t_abort();
        logic b;
        logic [31:0] seen = '0;
        send_word(rb_cmd(4));
        latch_pulse();
        for (int i = 0; i < 6; i++) rb_clock(b);
        latch_pulse();
        chk("R10 after abort latch", 32'(rdbk), 32'h0);
        for (int i = 0; i < 8; i++) begin
            rb_clock(b);
            seen[i] = b;
        end
        chk("R10 aborted readback silent", seen, 32'h0);
        check_all_regs("R10 regs unchanged");
    endtask

    task automatic t_simultaneous();
        logic b;
        logic [31:0] w = 32'h1234_5673;
        send_word(w);
        sdata = 1'b1;
        #16;
        sclk = 1'b1;
        slatch = 1'b1;
        #32 sclk = 1'b0;
        #16 slatch = 1'b0;
        #16;
        shadow[3] = w;
        chk("R9 write uses pre-shift word", get_reg(3), w);
        send_word(rb_cmd(3));
        sdata = 1'b1;
        #16;
        sclk = 1'b1;
        slatch = 1'b1;
        #32 sclk = 1'b0;
        #16 slatch = 1'b0;
        #16;
        rb_clock(b);
        chk("R9 next clock is idle", 32'(b), 32'h0);
        rb_clock(b);
        chk("R9 first data bit", 32'(b), 32'(w[0]));
        for (int i = 1; i < 33; i++) rb_clock(b);
        chk("R9 sequence ends", 32'(rdbk), 32'h0);
    endtask

    initial begin
        for (int k = 1; k <= 6; k++) shadow[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_ignore();
        t_no_rb();
        t_readback(3, pattern(3));
        t_readback(6, pattern(6));
        t_readback(0, rb_cmd(0));
        t_readback(7, 32'h0);
        t_abort();
        t_simultaneous();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule